// File: doc/BRIEF.md
# Condition-Driven Branch Sequencer

This block settles the control-flow outcome of one flow-control operation of a processor with 16-bit opcodes. A caller presents the opcode word, an operation kind, the program counter, the low 16 bits of a loop-count register and the four arithmetic flags N, Z, V and C, and pulses `start`. The block tests the 4-bit condition field of the opcode against the flags. It then resolves one of four operations: a conditional branch, an unconditional branch, a decrement-and-branch loop step, or a set-on-condition byte write. It returns the next program counter, an optional new loop count, a result byte and the clock-cycle cost of the path it took.

A displacement comes either from the signed low byte of the opcode or, when that byte is zero, from a signed 16-bit extension word. Memory fetch is not done here. When the chosen path needs the extension word, the block waits in a busy state until the caller supplies the word on a valid handshake. Paths that never use the word finish without waiting. The program counter presented with `start` must already point at the word after the opcode. All displacements are added to that value.

Top module: `cond_branch_seq`

## Requirements
- R1: The condition index is opcode bits 11:8, and the flags input is packed {N,Z,V,C} in bits 3:0. Index 0 is always true and index 1 is never true. The remaining indices, in pairs, are: 2 !C&!Z and 3 C|Z; 4 !C and 5 C; 6 !Z and 7 Z; 8 !V and 9 V; 10 !N and 11 N; 12 N==V and 13 N!=V; 14 (N==V)&!Z and 15 Z|(N!=V).
- R2: The operation kind is encoded as 0 conditional branch, 1 unconditional branch, 2 decrement-and-branch, 3 set-on-condition. A conditional branch whose condition holds and whose opcode low byte is nonzero returns pc plus the sign-extended low byte, costs 10 cycles, and raises `done` in the cycle after `start` is accepted.
- R3: A taken branch (kind 0 or 1) with a zero low byte sets `busy` and waits for `ext_valid`. It returns pc plus the sign-extended extension word and costs 10 cycles. `done` rises in the cycle after the clock edge that samples `ext_valid` high.
- R4: A conditional branch whose condition fails never waits for the extension word. With a nonzero low byte it returns pc unchanged at 8 cycles. With a zero low byte it returns pc+2 at 12 cycles.
- R5: An unconditional branch ignores the condition field and always takes its displacement, at 10 cycles.
- R6: A decrement-and-branch whose condition holds returns pc+2 at 12 cycles, does not wait for the extension word, and leaves `cnt_we` low.
- R7: A decrement-and-branch whose condition fails raises `cnt_we`, with `cnt_out` = `count_in`−1 (mod 2^16) and `cnt_reg` = opcode bits 2:0. If the new count is 0xFFFF, it returns pc+2 at 14 cycles without waiting. Otherwise it waits for the extension word and returns pc plus that word, sign-extended, at 10 cycles.
- R8: Set-on-condition returns `scc_byte` 0xFF at 6 cycles when the condition holds and 0x00 at 4 cycles when it fails. It returns pc unchanged and does not wait.
- R9: `done` is high for one cycle per accepted operation, and `cnt_we` is high only together with `done`. While `busy` is high, `start` is ignored and `done` stays low until `ext_valid` is sampled. The input values captured at the accepted `start` are used, whatever the inputs do later.
- R10: During and after reset, `done`, `busy` and `cnt_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept an operation (ignored while busy) |
| op_kind | input | 2 | Operation kind, encoded as in R2 |
| opcode | input | 16 | Opcode word |
| pc_in | input | PCW | Address of the word after the opcode |
| count_in | input | 16 | Low 16 bits of the loop-count register |
| flags_in | input | 4 | {N,Z,V,C} |
| ext_valid | input | 1 | Extension word valid |
| ext_word | input | 16 | Signed 16-bit extension displacement |
| busy | output | 1 | Waiting for the extension word |
| done | output | 1 | One-cycle result strobe |
| next_pc | output | PCW | Resolved program counter |
| cycles | output | CYW | Cycle cost of the path taken |
| cnt_we | output | 1 | Write-back strobe for the loop count |
| cnt_reg | output | 3 | Index of the register to write |
| cnt_out | output | 16 | Decremented loop count |
| scc_byte | output | 8 | Set-on-condition result byte |

## Verification
The bench targets the boundary between byte and word displacements: a zero low byte must switch to the extension word, while 0x80 must be treated as −128. A design that got this wrong would branch to the wrong target, or would stall waiting for a word on a not-taken branch. It drives loop counts of 0 and 1, so that both the 0xFFFF exit and the loop back to a count of zero are exercised. A decrement that wrapped wrongly, or an exit tested on the old count, would report the wrong target and cost. Extension words are delayed by random gaps while a new `start` is pushed in. A design that re-latched its inputs, or finished early, would return results for the wrong operation. All 16 conditions are swept against all 16 flag patterns, which exposes any swapped signed comparison.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
   typedef enum logic [1:0] {
      OP_BCOND = 2'd0,
      OP_BRA   = 2'd1,
      OP_DBCC  = 2'd2,
      OP_SCC   = 2'd3
   } cbs_kind_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } cbs_flags_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } cbs_state_e;

   function automatic int cbs_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/cbs_cond_eval.sv
module cbs_cond_eval
   import cbs_pkg::*;
(
   input  logic [3:0] sel,
   input  cbs_flags_t fl,
   output logic       hit
);
   logic sgn_ok;
   assign sgn_ok = (fl.n == fl.v);

   always_comb begin
      unique case (sel)
         4'd0:  hit = 1'b1;
         4'd1:  hit = 1'b0;
         4'd2:  hit = ~fl.c & ~fl.z;
         4'd3:  hit = fl.c | fl.z;
         4'd4:  hit = ~fl.c;
         4'd5:  hit = fl.c;
         4'd6:  hit = ~fl.z;
         4'd7:  hit = fl.z;
         4'd8:  hit = ~fl.v;
         4'd9:  hit = fl.v;
         4'd10: hit = ~fl.n;
         4'd11: hit = fl.n;
         4'd12: hit = sgn_ok;
         4'd13: hit = ~sgn_ok;
         4'd14: hit = sgn_ok & ~fl.z;
         default: hit = fl.z | ~sgn_ok;
      endcase
   end
endmodule

// File: rtl/cbs_disp_add.sv
module cbs_disp_add #(
   parameter int PCW = 32
) (
   input  logic [PCW-1:0] base,
   input  logic [15:0]    disp,
   output logic [PCW-1:0] sum
);
   logic [PCW-1:0] disp_x;

   generate
      if (PCW > 16) begin : g_wide
         assign disp_x = {{(PCW-16){disp[15]}}, disp};
      end else begin : g_narrow
         assign disp_x = disp[PCW-1:0];
      end
   endgenerate

   assign sum = base + disp_x;
endmodule

// File: rtl/cbs_resolve.sv
module cbs_resolve
   import cbs_pkg::*;
#(
   parameter int PCW            = 32,
   parameter int CYW            = 5,
   parameter int CYC_BR_TAKEN   = 10,
   parameter int CYC_BR_SKIP_B  = 8,
   parameter int CYC_BR_SKIP_W  = 12,
   parameter int CYC_DB_HIT     = 12,
   parameter int CYC_DB_EXPIRE  = 14,
   parameter int CYC_DB_LOOP    = 10,
   parameter int CYC_SET_TRUE   = 6,
   parameter int CYC_SET_FALSE  = 4
) (
   input  cbs_kind_e      kind,
   input  logic [15:0]    opcode,
   input  logic [PCW-1:0] pc,
   input  logic [15:0]    count,
   input  cbs_flags_t     fl,
   input  logic [15:0]    ext_word,
   output logic           need_ext,
   output logic [PCW-1:0] pc_next,
   output logic [CYW-1:0] cost,
   output logic           wr_cnt,
   output logic [15:0]    cnt_next,
   output logic [7:0]     set_byte
);
   localparam logic [15:0] CNT_WRAP = 16'hFFFF;

   logic           cond_hit;
   logic           short_zero;
   logic [15:0]    disp_short;
   logic [PCW-1:0] pc_short;
   logic [PCW-1:0] pc_word;
   logic [PCW-1:0] pc_skip;
   logic [15:0]    dec_val;

   assign short_zero = (opcode[7:0] == 8'h00);
   assign disp_short = {{8{opcode[7]}}, opcode[7:0]};
   assign dec_val    = count - 16'd1;

   cbs_cond_eval u_cond (
      .sel (opcode[11:8]),
      .fl  (fl),
      .hit (cond_hit)
   );

   cbs_disp_add #(.PCW(PCW)) u_add_short (
      .base (pc),
      .disp (disp_short),
      .sum  (pc_short)
   );

   cbs_disp_add #(.PCW(PCW)) u_add_word (
      .base (pc),
      .disp (ext_word),
      .sum  (pc_word)
   );

   cbs_disp_add #(.PCW(PCW)) u_add_skip (
      .base (pc),
      .disp (16'd2),
      .sum  (pc_skip)
   );

   always_comb begin
      need_ext = 1'b0;
      pc_next  = pc;
      cost     = '0;
      wr_cnt   = 1'b0;
      cnt_next = dec_val;
      set_byte = 8'h00;
      unique case (kind)
         OP_BCOND, OP_BRA: begin
            if (cond_hit || (kind == OP_BRA)) begin
               cost = CYW'(CYC_BR_TAKEN);
               if (short_zero) begin
                  need_ext = 1'b1;
                  pc_next  = pc_word;
               end else begin
                  pc_next  = pc_short;
               end
            end else if (short_zero) begin
               pc_next = pc_skip;
               cost    = CYW'(CYC_BR_SKIP_W);
            end else begin
               cost    = CYW'(CYC_BR_SKIP_B);
            end
         end
         OP_DBCC: begin
            if (cond_hit) begin
               pc_next = pc_skip;
               cost    = CYW'(CYC_DB_HIT);
            end else begin
               wr_cnt = 1'b1;
               if (dec_val == CNT_WRAP) begin
                  pc_next = pc_skip;
                  cost    = CYW'(CYC_DB_EXPIRE);
               end else begin
                  need_ext = 1'b1;
                  pc_next  = pc_word;
                  cost     = CYW'(CYC_DB_LOOP);
               end
            end
         end
         default: begin
            set_byte = cond_hit ? 8'hFF : 8'h00;
            cost     = cond_hit ? CYW'(CYC_SET_TRUE) : CYW'(CYC_SET_FALSE);
         end
      endcase
   end
endmodule

// File: rtl/cond_branch_seq.sv
module cond_branch_seq
   import cbs_pkg::*;
#(
   parameter int PCW            = 32,
   parameter int CYW            = 5,
   parameter int CYC_BR_TAKEN   = 10,
   parameter int CYC_BR_SKIP_B  = 8,
   parameter int CYC_BR_SKIP_W  = 12,
   parameter int CYC_DB_HIT     = 12,
   parameter int CYC_DB_EXPIRE  = 14,
   parameter int CYC_DB_LOOP    = 10,
   parameter int CYC_SET_TRUE   = 6,
   parameter int CYC_SET_FALSE  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [1:0]     op_kind,
   input  logic [15:0]    opcode,
   input  logic [PCW-1:0] pc_in,
   input  logic [15:0]    count_in,
   input  logic [3:0]     flags_in,
   input  logic           ext_valid,
   input  logic [15:0]    ext_word,
   output logic           busy,
   output logic           done,
   output logic [PCW-1:0] next_pc,
   output logic [CYW-1:0] cycles,
   output logic           cnt_we,
   output logic [2:0]     cnt_reg,
   output logic [15:0]    cnt_out,
   output logic [7:0]     scc_byte
);
   localparam int CYC_PEAK =
      cbs_max(cbs_max(cbs_max(CYC_BR_TAKEN, CYC_BR_SKIP_B), cbs_max(CYC_BR_SKIP_W, CYC_DB_HIT)),
              cbs_max(cbs_max(CYC_DB_EXPIRE, CYC_DB_LOOP), cbs_max(CYC_SET_TRUE, CYC_SET_FALSE)));

   generate
      if (PCW < 16) begin : g_bad_pcw
         $error("cond_branch_seq: PCW must be at least 16");
      end
      if (CYC_PEAK >= (1 << CYW)) begin : g_bad_cyw
         $error("cond_branch_seq: CYW too narrow for the largest cycle cost");
      end
   endgenerate

   cbs_state_e     state_q;
   cbs_kind_e      kind_q;
   logic [15:0]    opc_q;
   logic [PCW-1:0] pc_q;
   logic [15:0]    cnt_q;
   cbs_flags_t     fl_q;

   cbs_kind_e      src_kind;
   logic [15:0]    src_opc;
   logic [PCW-1:0] src_pc;
   logic [15:0]    src_cnt;
   cbs_flags_t     src_fl;

   logic           r_need;
   logic [PCW-1:0] r_pc;
   logic [CYW-1:0] r_cost;
   logic           r_we;
   logic [15:0]    r_cnt;
   logic [7:0]     r_set;

   logic           accept;
   logic           finish;

   assign accept = (state_q == ST_IDLE) && start;

   always_comb begin
      if (state_q == ST_IDLE) begin
         src_kind = cbs_kind_e'(op_kind);
         src_opc  = opcode;
         src_pc   = pc_in;
         src_cnt  = count_in;
         src_fl   = cbs_flags_t'(flags_in);
      end else begin
         src_kind = kind_q;
         src_opc  = opc_q;
         src_pc   = pc_q;
         src_cnt  = cnt_q;
         src_fl   = fl_q;
      end
   end

   cbs_resolve #(
      .PCW           (PCW),
      .CYW           (CYW),
      .CYC_BR_TAKEN  (CYC_BR_TAKEN),
      .CYC_BR_SKIP_B (CYC_BR_SKIP_B),
      .CYC_BR_SKIP_W (CYC_BR_SKIP_W),
      .CYC_DB_HIT    (CYC_DB_HIT),
      .CYC_DB_EXPIRE (CYC_DB_EXPIRE),
      .CYC_DB_LOOP   (CYC_DB_LOOP),
      .CYC_SET_TRUE  (CYC_SET_TRUE),
      .CYC_SET_FALSE (CYC_SET_FALSE)
   ) u_resolve (
      .kind     (src_kind),
      .opcode   (src_opc),
      .pc       (src_pc),
      .count    (src_cnt),
      .fl       (src_fl),
      .ext_word (ext_word),
      .need_ext (r_need),
      .pc_next  (r_pc),
      .cost     (r_cost),
      .wr_cnt   (r_we),
      .cnt_next (r_cnt),
      .set_byte (r_set)
   );

   assign finish = (accept && !r_need) || ((state_q == ST_WAIT) && ext_valid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= OP_BCOND;
         opc_q   <= '0;
         pc_q    <= '0;
         cnt_q   <= '0;
         fl_q    <= '0;
      end else begin
         if (accept && r_need) begin
            state_q <= ST_WAIT;
            kind_q  <= src_kind;
            opc_q   <= src_opc;
            pc_q    <= src_pc;
            cnt_q   <= src_cnt;
            fl_q    <= src_fl;
         end else if ((state_q == ST_WAIT) && ext_valid) begin
            state_q <= ST_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         cnt_we   <= 1'b0;
         next_pc  <= '0;
         cycles   <= '0;
         cnt_reg  <= '0;
         cnt_out  <= '0;
         scc_byte <= '0;
      end else begin
         done   <= finish;
         cnt_we <= finish && r_we;
         if (finish) begin
            next_pc  <= r_pc;
            cycles   <= r_cost;
            cnt_reg  <= src_opc[2:0];
            cnt_out  <= r_cnt;
            scc_byte <= r_set;
         end
      end
   end

   assign busy = (state_q == ST_WAIT);
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
   parameter int PCW           = 32,
   parameter int CYW           = 5,
   parameter int CYC_DB_EXPIRE = 14,
   parameter int CYC_SET_TRUE  = 6,
   parameter int CYC_SET_FALSE = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [1:0]     op_kind,
   input logic [PCW-1:0] pc_in,
   input logic [15:0]    count_in,
   input logic           ext_valid,
   input logic           busy,
   input logic           done,
   input logic [PCW-1:0] next_pc,
   input logic [CYW-1:0] cycles,
   input logic           cnt_we,
   input logic [15:0]    cnt_out,
   input logic [7:0]     scc_byte
);
   logic [PCW-1:0] cap_pc;
   logic [15:0]    cap_cnt;
   logic [1:0]     cap_kind;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_pc   <= '0;
         cap_cnt  <= '0;
         cap_kind <= '0;
      end else if (start && !busy) begin
         cap_pc   <= pc_in;
         cap_cnt  <= count_in;
         cap_kind <= op_kind;
      end
   end

   a_r7_count_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cnt_we) |-> (cnt_out == cap_cnt - 16'd1));

   a_r7_expire_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cnt_we && cnt_out == 16'hFFFF) |->
         (cycles == CYW'(CYC_DB_EXPIRE) && next_pc == cap_pc + PCW'(2)));

   a_r8_set_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cap_kind == 2'd3) |->
         ((scc_byte == 8'hFF && cycles == CYW'(CYC_SET_TRUE)) ||
          (scc_byte == 8'h00 && cycles == CYW'(CYC_SET_FALSE))));

   a_r9_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ext_valid) |=> !done);

   a_r3_ext_finish: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ext_valid) |=> (done && !busy));

   a_r9_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |-> done);
endmodule

bind cond_branch_seq cbs_checker #(
   .PCW           (PCW),
   .CYW           (CYW),
   .CYC_DB_EXPIRE (CYC_DB_EXPIRE),
   .CYC_SET_TRUE  (CYC_SET_TRUE),
   .CYC_SET_FALSE (CYC_SET_FALSE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op_kind   (op_kind),
   .pc_in     (pc_in),
   .count_in  (count_in),
   .ext_valid (ext_valid),
   .busy      (busy),
   .done      (done),
   .next_pc   (next_pc),
   .cycles    (cycles),
   .cnt_we    (cnt_we),
   .cnt_out   (cnt_out),
   .scc_byte  (scc_byte)
);

// File: tb/cond_branch_seq_test.sv
module cond_branch_seq_test;
   localparam int PCW = 32;
   localparam int CYW = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [1:0]     op_kind = '0;
   logic [15:0]    opcode = '0;
   logic [PCW-1:0] pc_in = '0;
   logic [15:0]    count_in = '0;
   logic [3:0]     flags_in = '0;
   logic           ext_valid = 1'b0;
   logic [15:0]    ext_word = '0;
   logic           busy;
   logic           done;
   logic [PCW-1:0] next_pc;
   logic [CYW-1:0] cycles;
   logic           cnt_we;
   logic [2:0]     cnt_reg;
   logic [15:0]    cnt_out;
   logic [7:0]     scc_byte;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   cond_branch_seq #(.PCW(PCW), .CYW(CYW)) uut (
      .clk (clk), .rst_n (rst_n), .start (start), .op_kind (op_kind),
      .opcode (opcode), .pc_in (pc_in), .count_in (count_in),
      .flags_in (flags_in), .ext_valid (ext_valid), .ext_word (ext_word),
      .busy (busy), .done (done), .next_pc (next_pc), .cycles (cycles),
      .cnt_we (cnt_we), .cnt_reg (cnt_reg), .cnt_out (cnt_out),
      .scc_byte (scc_byte)
   );

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // R1: flags packed {N,Z,V,C}
   function automatic bit ref_cond(input logic [3:0] c, input logic [3:0] f);
      bit n, z, v, cy;
      n = f[3]; z = f[2]; v = f[1]; cy = f[0];
      case (c)
         4'd0:  return 1'b1;
         4'd1:  return 1'b0;
         4'd2:  return !cy && !z;
         4'd3:  return cy || z;
         4'd4:  return !cy;
         4'd5:  return cy;
         4'd6:  return !z;
         4'd7:  return z;
         4'd8:  return !v;
         4'd9:  return v;
         4'd10: return !n;
         4'd11: return n;
         4'd12: return n == v;
         4'd13: return n != v;
         4'd14: return (n == v) && !z;
         default: return z || (n != v);
      endcase
   endfunction

   function automatic logic [31:0] sx8(input logic [7:0] b);
      return {{24{b[7]}}, b};
   endfunction

   function automatic logic [31:0] sx16(input logic [15:0] w);
      return {{16{w[15]}}, w};
   endfunction

   task automatic run_op(input logic [1:0] kind, input logic [15:0] opc,
                         input logic [31:0] pc, input logic [15:0] cnt,
                         input logic [3:0] fl, input logic [15:0] ext,
                         input int delay, input bit poke);
      bit          hit, e_need, e_we;
      logic [31:0] e_pc;
      int          e_cyc;
      logic [15:0] e_cnt;
      logic [7:0]  e_scc;
      string       tag;
      hit    = ref_cond(opc[11:8], fl);
      e_need = 0; e_we = 0; e_pc = pc; e_cnt = cnt - 16'd1; e_scc = 8'h00;
      e_cyc  = 0; tag = "";
      case (kind)
         2'd0, 2'd1: begin
            if (hit || kind == 2'd1) begin
               e_cyc = 10;
               if (opc[7:0] == 8'h00) begin
                  e_need = 1; e_pc = pc + sx16(ext); tag = "R3";
               end else begin
                  e_pc = pc + sx8(opc[7:0]);
                  tag = (kind == 2'd1) ? "R5" : "R2";
               end
            end else if (opc[7:0] == 8'h00) begin
               e_pc = pc + 32'd2; e_cyc = 12; tag = "R4";
            end else begin
               e_cyc = 8; tag = "R4";
            end
         end
         2'd2: begin
            if (hit) begin
               e_pc = pc + 32'd2; e_cyc = 12; tag = "R6";
            end else begin
               e_we = 1; tag = "R7";
               if (e_cnt == 16'hFFFF) begin
                  e_pc = pc + 32'd2; e_cyc = 14;
               end else begin
                  e_need = 1; e_pc = pc + sx16(ext); e_cyc = 10;
               end
            end
         end
         default: begin
            e_scc = hit ? 8'hFF : 8'h00; e_cyc = hit ? 6 : 4; tag = "R8";
         end
      endcase

      @(negedge clk);
      chk("R9", "done low between operations", done, 0);
      start = 1'b1; op_kind = kind; opcode = opc; pc_in = pc;
      count_in = cnt; flags_in = fl; ext_valid = 1'b0; ext_word = $urandom;
      @(negedge clk);
      start = 1'b0;
      opcode = $urandom; pc_in = $urandom; count_in = $urandom; flags_in = $urandom;
      if (e_need) begin
         chk(tag, "busy while waiting for word", busy, 1);
         chk("R9", "no done before word", done, 0);
         for (int i = 0; i < delay; i++) begin
            if (poke) begin
               start = 1'b1; op_kind = 2'd3;
            end
            @(negedge clk);
            start = 1'b0;
            chk("R9", "still waiting, start ignored", {busy, done}, 2'b10);
         end
         ext_valid = 1'b1; ext_word = ext;
         @(negedge clk);
         ext_valid = 1'b0; ext_word = $urandom;
      end
      chk(tag, "done strobe", done, 1);
      chk(tag, "busy after finish", busy, 0);
      chk(tag, "next_pc", next_pc, e_pc);
      chk(tag, "cycles", cycles, e_cyc);
      chk(tag, "cnt_we", cnt_we, e_we);
      if (e_we) begin
         chk("R7", "cnt_out", cnt_out, e_cnt);
         chk("R7", "cnt_reg", cnt_reg, opc[2:0]);
      end
      if (kind == 2'd3) chk(tag, "scc_byte", scc_byte, e_scc);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'h5EED_C0DE));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10", "done in reset", done, 0);
      chk("R10", "busy in reset", busy, 0);
      chk("R10", "cnt_we in reset", cnt_we, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "done after reset", done, 0);
      chk("R10", "busy after reset", busy, 0);

      // R1: every condition against every flag pattern through set-on-condition
      for (int c = 0; c < 16; c++)
         for (int f = 0; f < 16; f++)
            run_op(2'd3, {4'h5, 4'(c), 8'hC3}, 32'h0000_1000, 16'h0, 4'(f), 16'h0, 0, 0);

      // R2 negative byte limit
      run_op(2'd0, 16'h6080, 32'h0000_2000, 16'h0, 4'h0, 16'h0, 0, 0);
      // R2 positive byte limit
      run_op(2'd0, 16'h677F, 32'h0000_2000, 16'h0, 4'h4, 16'h0, 0, 0);
      // R3 most negative word displacement, with delay and poke
      run_op(2'd0, 16'h6600, 32'h0001_0000, 16'h0, 4'h0, 16'h8000, 3, 1);
      // R4 not-taken, word form skips the word
      run_op(2'd0, 16'h6700, 32'h0000_3000, 16'h0, 4'h0, 16'h1234, 0, 0);
      // R4 not-taken, byte form
      run_op(2'd0, 16'h6712, 32'h0000_3000, 16'h0, 4'h0, 16'h1234, 0, 0);
      // R5 unconditional with the never-true condition field
      run_op(2'd1, 16'h61F0, 32'h0000_4000, 16'h0, 4'hF, 16'h0, 0, 0);
      run_op(2'd1, 16'h6100, 32'h0000_4000, 16'h0, 4'hF, 16'h7FFE, 2, 1);
      // R6 true condition exits at once
      run_op(2'd2, 16'h50C9, 32'h0000_5000, 16'h0005, 4'h0, 16'hFFF0, 0, 0);
      // R7 count 0 wraps to FFFF and exits
      run_op(2'd2, 16'h51CB, 32'h0000_5000, 16'h0000, 4'h0, 16'hFFF0, 0, 0);
      // R7 count 1 goes to 0 and loops back
      run_op(2'd2, 16'h51CE, 32'h0000_5000, 16'h0001, 4'h0, 16'hFFF0, 1, 1);

      for (int i = 0; i < 600; i++) begin
         logic [15:0] opc;
         logic [15:0] cnt;
         opc = 16'($urandom);
         if ($urandom % 3 == 0) opc[7:0] = 8'h00;
         cnt = ($urandom % 4 == 0) ? 16'($urandom % 2) : 16'($urandom);
         run_op(2'($urandom), opc, {$urandom, 1'b0} , cnt, 4'($urandom),
                16'($urandom), int'($urandom % 3), ($urandom % 4 == 0));
      end

      @(negedge clk);
      chk("R9", "idle at end", {busy, done}, 2'b00);
      summary();
   end
endmodule